// File: doc/BRIEF.md
# Instruction Prefix Decoder and Repeat Sequencer

This block sits beside the decode stage of a 16-bit processor that addresses a 20-bit space. It watches every fetched word. A word whose top five bits are 00011 (values 1800h to 1FFFh) is a prefix and not an instruction. The block holds the prefix's fields until the next real instruction is decoded, then applies them to that instruction.

A prefix sets three things for the instruction that follows it. It sets the operand size, using a length bit in the prefix together with the instruction's own byte/word bit. It can force the carry fed to the arithmetic unit to zero. It sets a repeat count of 1 to 16, taken either from a 4-bit immediate field or from the low nibble of a register that the prefix names. The block reads that register through a register-file read port.

While the instruction runs, the block asks the core to issue it again after each completion strobe until every pass has been done. After the last pass the prefix state clears.

Top module: `xw_seq`

## Requirements
- R1: A fetched word with bits 15:11 equal to 00011 is held as a pending prefix. It is not treated as an instruction, so op_size, addr20 and rep_active keep their values.
- R2: op_size encodes 2'b00 as 8-bit, 2'b01 as 16-bit and 2'b10 as 20-bit. The values are set on the decode of a non-prefix word and are visible the cycle after it is fetched. After a prefix with length bit 6 = 1, ins_bw=1 gives 8-bit and ins_bw=0 gives 16-bit. After a prefix with bit 6 = 0, ins_bw=1 gives 20-bit. With no prefix, ins_bw=1 gives 8-bit and ins_bw=0 gives 16-bit.
- R3: After a prefix with bit 6 = 0, an instruction with ins_bw=0 raises size_illegal and gives op_size 2'b01.
- R4: addr20 is 1 for an instruction that had a prefix and 0 for one that did not.
- R5: With prefix bit 7 = 0, bits 3:0 hold n−1 and the instruction runs n times. reissue pulses for one cycle after each of the first n−1 exec_done strobes and never after the last one.
- R6: With prefix bit 7 = 1, rf_rd_idx shows prefix bits 3:0 while the prefix is pending. The low nibble of rf_rd_data, taken when the instruction is decoded, holds n−1. Later changes to that register do not change n.
- R7: rep_active is 1 from the cycle after a prefixed instruction is decoded until the cycle after its final exec_done.
- R8: With prefix bit 8 = 1, carry_op is 0 in every pass of the prefixed instruction. With bit 8 = 0, and outside prefixed instructions, carry_op follows carry_in.
- R9: Prefix bits 10:9 and 5:4 have no effect on size, addressing, count or carry.
- R10: A second prefix fetched while one is pending replaces it completely.
- R11: After the final pass of a prefixed instruction the prefix state is gone. The next instruction without a prefix has addr20=0, its plain size, a single pass and rep_active=0.
- R12: Words fetched while an instruction is executing (before its final exec_done) are ignored, whether they are prefixes or instructions.
- R13: After reset, op_size=2'b01 and size_illegal, addr20, rep_active and reissue are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | fetch_word holds a newly fetched word |
| fetch_word | input | 16 | Fetched opcode word |
| ins_bw | input | 1 | Byte/word bit of the fetched instruction |
| rf_rd_idx | output | 4 | Register index for the count read |
| rf_rd_data | input | 16 | Contents of register rf_rd_idx |
| exec_done | input | 1 | Current pass of the instruction finished |
| carry_in | input | 1 | Live carry flag |
| op_size | output | 2 | Operand size code (see R2) |
| size_illegal | output | 1 | Reserved size combination was used |
| addr20 | output | 1 | Addresses and immediates are 20-bit |
| carry_op | output | 1 | Carry fed to the arithmetic unit |
| rep_active | output | 1 | A prefixed instruction is being repeated |
| reissue | output | 1 | Request to issue the instruction again |

## Verification
Immediate counts of 0, 4 and 15 test the single-pass case, a middle value and the full 16-pass limit, and each pass is counted through reissue pulses. A register-sourced count, with the register rewritten after the first pass, shows whether the count is captured once or read again on every pass. Prefixes that set the reserved bits, two prefixes in a row, and a prefix fetched in the middle of a repeat show apart three cases: fields being ignored, fields being replaced, and fetches being ignored. Every combination of length bit and byte/word bit is driven, with and without a prefix, to cover the size map and the illegal-size flag.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_ADDR = 2'b10
  } opsz_e;

  localparam logic [4:0] XW_TAG    = 5'b00011;
  localparam int         XW_ZC_BIT = 8;
  localparam int         XW_RS_BIT = 7;
  localparam int         XW_AL_BIT = 6;

  typedef struct packed {
    logic       zc;
    logic       from_reg;
    logic       al;
    logic [3:0] cnt;
  } xw_fields_t;
endpackage

// File: rtl/xw_prefix_hold.sv
module xw_prefix_hold
  import xw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              fetch_vld,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              is_prefix,
  output logic              pend_vld,
  output xw_fields_t        pend
);
  localparam int TAG_LSB = WORD_W - 5;

  assign is_prefix = (fetch_word[WORD_W-1:TAG_LSB] == XW_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend     <= '0;
    end else if (accept && fetch_vld) begin
      if (is_prefix) begin
        pend_vld      <= 1'b1;
        pend.zc       <= fetch_word[XW_ZC_BIT];
        pend.from_reg <= fetch_word[XW_RS_BIT];
        pend.al       <= fetch_word[XW_AL_BIT];
        pend.cnt      <= fetch_word[3:0];
      end else begin
        pend_vld <= 1'b0;
        pend     <= '0;
      end
    end
  end
endmodule

// File: rtl/xw_size_sel.sv
module xw_size_sel
  import xw_pkg::*;
(
  input  logic  ext,
  input  logic  al,
  input  logic  bw,
  output opsz_e size,
  output logic  illegal
);
  always_comb begin
    illegal = 1'b0;
    if (!ext) begin
      size = bw ? SZ_BYTE : SZ_WORD;
    end else begin
      unique case ({al, bw})
        2'b11:   size = SZ_BYTE;
        2'b10:   size = SZ_WORD;
        2'b01:   size = SZ_ADDR;
        default: begin
          size    = SZ_WORD;
          illegal = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/xw_rep_ctr.sv
module xw_rep_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             done,
  output logic             busy,
  output logic             fin,
  output logic             reissue
);
  logic [CNT_W-1:0] rem_q;

  assign fin = busy && done && (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rem_q   <= '0;
      reissue <= 1'b0;
    end else begin
      reissue <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        rem_q <= load_val;
      end else if (busy && done) begin
        if (rem_q == '0) begin
          busy <= 1'b0;
        end else begin
          rem_q   <= rem_q - 1'b1;
          reissue <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xw_seq.sv
module xw_seq
  import xw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4,
  parameter int RF_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              ins_bw,
  output logic [CNT_W-1:0]  rf_rd_idx,
  input  logic [RF_W-1:0]   rf_rd_data,
  input  logic              exec_done,
  input  logic              carry_in,
  output logic [1:0]        op_size,
  output logic              size_illegal,
  output logic              addr20,
  output logic              carry_op,
  output logic              rep_active,
  output logic              reissue
);
  logic       is_prefix, pend_vld, busy, fin, decode, illegal_d;
  xw_fields_t pend;
  opsz_e      size_d;
  logic [CNT_W-1:0] cnt_d;
  logic       zc_q;

  assign decode = !busy && fetch_vld && !is_prefix;

  xw_prefix_hold #(.WORD_W(WORD_W)) hold_i (
    .clk(clk), .rst(rst), .accept(!busy), .fetch_vld(fetch_vld),
    .fetch_word(fetch_word), .is_prefix(is_prefix),
    .pend_vld(pend_vld), .pend(pend)
  );

  xw_size_sel size_i (
    .ext(pend_vld), .al(pend.al), .bw(ins_bw),
    .size(size_d), .illegal(illegal_d)
  );

  assign rf_rd_idx = pend.cnt[CNT_W-1:0];

  always_comb begin
    if (!pend_vld)         cnt_d = '0;
    else if (pend.from_reg) cnt_d = rf_rd_data[CNT_W-1:0];
    else                   cnt_d = pend.cnt[CNT_W-1:0];
  end

  xw_rep_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .load(decode), .load_val(cnt_d),
    .done(exec_done), .busy(busy), .fin(fin), .reissue(reissue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_size      <= SZ_WORD;
      size_illegal <= 1'b0;
      addr20       <= 1'b0;
      rep_active   <= 1'b0;
      zc_q         <= 1'b0;
    end else if (decode) begin
      op_size      <= size_d;
      size_illegal <= illegal_d;
      addr20       <= pend_vld;
      rep_active   <= pend_vld;
      zc_q         <= pend_vld && pend.zc;
    end else if (fin) begin
      rep_active   <= 1'b0;
      zc_q         <= 1'b0;
    end
  end

  assign carry_op = carry_in && !zc_q;
endmodule

// File: rtl/xw_seq_chk.sv
module xw_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       exec_done,
  input logic       reissue,
  input logic       rep_active,
  input logic       carry_op,
  input logic       zc_hold,
  input logic       size_illegal,
  input logic [1:0] op_size
);
  assert_reissue_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    reissue |-> $past(exec_done));

  assert_reissue_in_repeat_R7: assert property (@(posedge clk) disable iff (rst)
    reissue |-> rep_active);

  assert_repeat_end_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rep_active) |-> $past(exec_done));

  assert_illegal_is_word_R3: assert property (@(posedge clk) disable iff (rst)
    size_illegal |-> (op_size == 2'b01));

  assert_zc_zero_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (rep_active && zc_hold) |-> !carry_op);

  assert_size_code_valid_R2: assert property (@(posedge clk) disable iff (rst)
    op_size != 2'b11);
endmodule

bind xw_seq xw_seq_chk chk_i (
  .clk(clk), .rst(rst), .exec_done(exec_done), .reissue(reissue),
  .rep_active(rep_active), .carry_op(carry_op), .zc_hold(zc_q),
  .size_illegal(size_illegal), .op_size(op_size)
);

// File: tb/xw_seq_tb.sv
module xw_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_vld = 1'b0;
  logic [15:0] fetch_word = '0;
  logic        ins_bw = 1'b0;
  logic [3:0]  rf_rd_idx;
  logic [15:0] rf_rd_data;
  logic        exec_done = 1'b0;
  logic        carry_in = 1'b0;
  logic [1:0]  op_size;
  logic        size_illegal, addr20, carry_op, rep_active, reissue;
  logic [15:0] regs [16];
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;
  assign rf_rd_data = regs[rf_rd_idx];

  xw_seq dut_i (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
    .ins_bw(ins_bw), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .exec_done(exec_done), .carry_in(carry_in), .op_size(op_size),
    .size_illegal(size_illegal), .addr20(addr20), .carry_op(carry_op),
    .rep_active(rep_active), .reissue(reissue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkx(input logic zc, input logic rs,
                                      input logic al, input logic [3:0] c);
    mkx = 16'h1800 | (16'(zc) << 8) | (16'(rs) << 7) | (16'(al) << 6) | 16'(c);
  endfunction

  task automatic do_fetch(input logic [15:0] w, input logic bw);
    fetch_vld = 1'b1; fetch_word = w; ins_bw = bw;
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic do_done();
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  task automatic run_to_end(output int execs);
    execs = 1;
    for (int k = 0; k < 20; k++) begin
      do_done();
      if (reissue) execs++;
      else break;
    end
  endtask

  task automatic t_reset();
    chk("R13 op_size", 32'(op_size), 32'h1);
    chk("R13 flags", {size_illegal, addr20, rep_active, reissue}, 32'h0);
  endtask

  task automatic t_prefix_only();
    int e;
    do_fetch(mkx(0, 1, 1, 4'hB), 1'b0);
    chk("R1 no rep", 32'(rep_active), 32'h0);
    chk("R1 addr unchanged", 32'(addr20), 32'h0);
    chk("R1 size unchanged", 32'(op_size), 32'h1);
    chk("R6 idx", 32'(rf_rd_idx), 32'hB);
    regs[11] = 16'h0000;
    do_fetch(16'h4000, 1'b0);
    run_to_end(e);
    chk("R6 reg count 1", 32'(e), 32'd1);
  endtask

  task automatic t_sizes();
    int e;
    do_fetch(mkx(0, 0, 1, 0), 1'b0); do_fetch(16'h4000, 1'b0);
    chk("R2 al1 bw0", 32'(op_size), 32'h1);
    chk("R4 prefixed addr20", 32'(addr20), 32'h1);
    chk("R3 legal", 32'(size_illegal), 32'h0);
    run_to_end(e);
    do_fetch(mkx(0, 0, 1, 0), 1'b1); do_fetch(16'h4000, 1'b1);
    chk("R2 al1 bw1", 32'(op_size), 32'h0);
    run_to_end(e);
    do_fetch(mkx(0, 0, 0, 0), 1'b1); do_fetch(16'h4000, 1'b1);
    chk("R2 al0 bw1", 32'(op_size), 32'h2);
    run_to_end(e);
    do_fetch(16'h4000, 1'b1);
    chk("R2 plain bw1", 32'(op_size), 32'h0);
    chk("R4 plain addr20", 32'(addr20), 32'h0);
    run_to_end(e);
    do_fetch(16'h4000, 1'b0);
    chk("R2 plain bw0", 32'(op_size), 32'h1);
    run_to_end(e);
  endtask

  task automatic t_reserved_size();
    int e;
    do_fetch(mkx(0, 0, 0, 0), 1'b0); do_fetch(16'h4000, 1'b0);
    chk("R3 illegal", 32'(size_illegal), 32'h1);
    chk("R3 size", 32'(op_size), 32'h1);
    run_to_end(e);
  endtask

  task automatic t_imm_count(input logic [3:0] c);
    int e;
    do_fetch(mkx(0, 0, 1, c), 1'b0); do_fetch(16'h4000, 1'b0);
    chk("R7 active", 32'(rep_active), 32'h1);
    run_to_end(e);
    chk("R5 passes", 32'(e), 32'(c) + 1);
    chk("R7 dropped", 32'(rep_active), 32'h0);
    chk("R5 no trailing reissue", 32'(reissue), 32'h0);
  endtask

  task automatic t_reg_count();
    int e;
    regs[9] = 16'h00A7;
    do_fetch(mkx(0, 1, 1, 4'd9), 1'b0);
    chk("R6 idx 9", 32'(rf_rd_idx), 32'h9);
    do_fetch(16'h4000, 1'b0);
    do_done();
    regs[9] = 16'h0002;
    e = 2;
    for (int k = 0; k < 20; k++) begin
      do_done();
      if (reissue) e++;
      else break;
    end
    chk("R6 captured count", 32'(e), 32'd8);
  endtask

  task automatic t_carry();
    int e;
    carry_in = 1'b1;
    do_fetch(mkx(1, 0, 1, 4'd2), 1'b0); do_fetch(16'h4000, 1'b0);
    #1 chk("R8 zc pass1", 32'(carry_op), 32'h0);
    do_done(); #1 chk("R8 zc pass2", 32'(carry_op), 32'h0);
    do_done(); #1 chk("R8 zc pass3", 32'(carry_op), 32'h0);
    do_done(); #1 chk("R8 after", 32'(carry_op), 32'h1);
    chk("R11 ended", 32'(rep_active), 32'h0);
    do_fetch(mkx(0, 0, 1, 4'd1), 1'b0); do_fetch(16'h4000, 1'b0);
    #1 chk("R8 zc0 follows", 32'(carry_op), 32'h1);
    carry_in = 1'b0;
    #1 chk("R8 zc0 follows low", 32'(carry_op), 32'h0);
    run_to_end(e);
  endtask

  task automatic t_reserved_bits();
    int e;
    carry_in = 1'b1;
    do_fetch(16'h1E72, 1'b0); do_fetch(16'h4000, 1'b0);
    chk("R9 size", 32'(op_size), 32'h1);
    chk("R9 addr20", 32'(addr20), 32'h1);
    #1 chk("R9 carry", 32'(carry_op), 32'h1);
    run_to_end(e);
    chk("R9 passes", 32'(e), 32'd3);
    carry_in = 1'b0;
  endtask

  task automatic t_replace();
    int e;
    carry_in = 1'b1;
    do_fetch(mkx(1, 0, 1, 4'd5), 1'b0);
    do_fetch(mkx(0, 0, 0, 4'd1), 1'b1);
    do_fetch(16'h4000, 1'b1);
    chk("R10 size", 32'(op_size), 32'h2);
    #1 chk("R10 carry", 32'(carry_op), 32'h1);
    run_to_end(e);
    chk("R10 passes", 32'(e), 32'd2);
    carry_in = 1'b0;
  endtask

  task automatic t_clear();
    int e;
    do_fetch(mkx(0, 0, 0, 4'd3), 1'b1); do_fetch(16'h4000, 1'b1);
    run_to_end(e);
    do_fetch(16'h4000, 1'b0);
    chk("R11 addr20", 32'(addr20), 32'h0);
    chk("R11 size", 32'(op_size), 32'h1);
    chk("R11 no rep", 32'(rep_active), 32'h0);
    run_to_end(e);
    chk("R11 passes", 32'(e), 32'd1);
  endtask

  task automatic t_busy_ignore();
    int e;
    do_fetch(mkx(0, 0, 0, 4'd2), 1'b1); do_fetch(16'h4000, 1'b1);
    do_fetch(mkx(0, 0, 1, 4'd7), 1'b0);
    do_fetch(16'h4000, 1'b0);
    chk("R12 size held", 32'(op_size), 32'h2);
    chk("R12 active held", 32'(rep_active), 32'h1);
    run_to_end(e);
    chk("R12 passes", 32'(e), 32'd3);
    do_fetch(16'h4000, 1'b1);
    chk("R12 prefix dropped", 32'(addr20), 32'h0);
    chk("R12 plain size", 32'(op_size), 32'h0);
    run_to_end(e);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prefix_only();
    t_sizes();
    t_reserved_size();
    t_imm_count(4'd0);
    t_imm_count(4'd4);
    t_imm_count(4'd15);
    t_reg_count();
    t_carry();
    t_reserved_bits();
    t_replace();
    t_clear();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule